// File: doc/BRIEF.md
# External-Master Chip-Select and Acknowledge Controller

This block serves bus cycles that another bus master runs once it has been given the bus. While ownership is handed over and that master pulses its transfer-start strobe, the block registers the address, the direction and the size code. On the next clock it matches the captured address against a set of programmable chip-select windows. It then drives the chosen chip select and the byte write enables for the beat pattern that the transfer size and the region's port width call for. Optionally it also paces and drives the transfer acknowledge after a programmed number of wait states.

An address that hits no window falls to a default memory region. That region has no chip select of its own, but it has its own acknowledge, wait-state, burst and port-width settings. The block never drives the address bus, and the external master keeps the address valid itself. All region settings are static configuration inputs that a neighbouring register block provides.

Top module: `emcs_ctrl`

## Requirements
- R1: A transfer is captured only at a rising clock edge where `ext_grant_i` and `ts_i` are both high and the block is idle. A strobe with `ext_grant_i` low produces no chip select and no acknowledge.
- R2: Address, `rd_i` (1 = read) and `size_i` are registered at the capture edge. Chip select first shows high after the next rising edge, which is one clock after the capture edge.
- R3: Window i matches when `((addr ^ base_i) & mask_i) == 0`, where a mask bit of 1 means the bit is compared. When windows overlap, the lowest-index match wins. `cs_o[i]` is active high, and at most one bit is ever set.
- R4: A matched window that is not enabled for the transfer's direction asserts nothing: no chip select, no write enable, no acknowledge and no acknowledge drive.
- R5: When the selected region has auto-acknowledge set, `ta_oe_o` is high for the whole access. For every beat, `ta_o` stays low for the region's wait-state count of clocks and is then high for exactly one clock.
- R6: When the selected window has auto-acknowledge clear, `ta_oe_o` and `ta_o` stay low. The chip select is still held for beats × (wait states + 1) clocks.
- R7: An address that matches no window uses the default region. No chip select and no write enable are asserted, and the acknowledge follows the default auto-acknowledge, wait-state, burst and port settings.
- R8: The size codes are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes and 11 = 16 bytes. The port codes are 00 = 8-bit, 01 = 16-bit and 1x = 32-bit. When burst is enabled and the transfer is wider than the port, the beat count is bytes / port bytes; otherwise there is one beat.
- R9: On a write to a window, `we_o[k]` (active high) marks byte lane k, which holds address offset k within the port. The lanes covered are min(transfer, port) bytes, starting at the address offset within the port aligned down to that size. Reads drive no write enable.
- R10: Chip select, write enables and acknowledge drive all deassert on the clock after the final acknowledge beat. A strobe sampled on the following edge starts a new transfer.
- R11: A strobe that arrives while a transfer is being decoded or run is ignored.
- R12: When `hi_addr_en_i` is 0, address bits [27:24] are captured as zero before decoding.
- R13: In reset, every output is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_grant_i | input | 1 | Bus is owned by the other master |
| ts_i | input | 1 | Transfer-start strobe from the other master |
| addr_i | input | 28 | Transfer address |
| rd_i | input | 1 | 1 = read, 0 = write |
| size_i | input | 2 | Transfer size code |
| hi_addr_en_i | input | 1 | Upper four address pins carry address |
| win_base_i | input | 4*28 | Window base addresses, window i at bits [28i+27:28i] |
| win_mask_i | input | 4*28 | Window compare masks, same packing |
| win_rd_en_i | input | 4 | Window enabled for reads |
| win_wr_en_i | input | 4 | Window enabled for writes |
| win_aack_i | input | 4 | Window auto-acknowledge enable |
| win_burst_i | input | 4 | Window burst enable |
| win_port_i | input | 4*2 | Window port-width codes |
| win_ws_i | input | 4*4 | Window wait-state counts |
| dflt_aack_i | input | 1 | Default region auto-acknowledge enable |
| dflt_burst_i | input | 1 | Default region burst enable |
| dflt_port_i | input | 2 | Default region port-width code |
| dflt_ws_i | input | 4 | Default region wait-state count |
| cs_o | output | 4 | Chip selects, active high |
| we_o | output | 4 | Byte-lane write enables, active high |
| ta_o | output | 1 | Transfer acknowledge pulse |
| ta_oe_o | output | 1 | Acknowledge drive enable |

## Verification
The bench aims at beat pacing in every combination that matters: a 16-byte line into a 32-bit port, a word into an 8-bit port with no wait states, and a 16-bit port with burst disabled. A design that divides by the wrong width or ignores the burst enable gives the wrong number of acknowledge pulses. Overlapping windows and the upper-address masking test the decoder; a priority or masking fault selects the wrong chip select or falls through to the default region. Write-lane placement is checked at odd offsets in 16-bit and 32-bit ports, where an alignment error moves the enable to the wrong lane. A strobe held high for many clocks checks that nothing is captured mid-access and that the block accepts again exactly one idle clock after the final acknowledge. An off-by-one in the idle or busy handling shifts every later transfer and breaks the per-clock comparison.

// File: rtl/emcs_pkg.sv
package emcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_RUN    = 2'd2
    } emcs_state_e;

    localparam logic [1:0] SZ_LONG = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] SZ_LINE = 2'b11;

    localparam logic [1:0] PS_8  = 2'b00;
    localparam logic [1:0] PS_16 = 2'b01;

    // log2 of the transfer length in bytes
    function automatic logic [2:0] xfer_log2(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd0;
            SZ_WORD: return 3'd1;
            SZ_LONG: return 3'd2;
            SZ_LINE: return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

    // log2 of the port width in bytes
    function automatic logic [2:0] port_log2(input logic [1:0] ps);
        case (ps)
            PS_8:    return 3'd0;
            PS_16:   return 3'd1;
            default: return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/emcs_match.sv
// Address window compare with lowest-index priority.
module emcs_match #(
    parameter int NWIN = 4,
    parameter int AW   = 28
) (
    input  logic [AW-1:0]      addr_i,
    input  logic [NWIN*AW-1:0] base_i,
    input  logic [NWIN*AW-1:0] mask_i,
    output logic [NWIN-1:0]    sel_o,
    output logic               hit_o
);

    logic [NWIN-1:0] raw;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        assign raw[g] = ((addr_i ^ base_i[g*AW +: AW]) & mask_i[g*AW +: AW]) == '0;
    end

    // isolate the lowest set bit
    assign sel_o = raw & (~raw + NWIN'(1));
    assign hit_o = |raw;

endmodule

// File: rtl/emcs_cfg_sel.sv
// Picks the settings of the selected window, or of the default region.
module emcs_cfg_sel #(
    parameter int NWIN = 4,
    parameter int WSW  = 4
) (
    input  logic [NWIN-1:0]     sel_i,
    input  logic                hit_i,
    input  logic [NWIN-1:0]     win_rd_en_i,
    input  logic [NWIN-1:0]     win_wr_en_i,
    input  logic [NWIN-1:0]     win_aack_i,
    input  logic [NWIN-1:0]     win_burst_i,
    input  logic [NWIN*2-1:0]   win_port_i,
    input  logic [NWIN*WSW-1:0] win_ws_i,
    input  logic                dflt_aack_i,
    input  logic                dflt_burst_i,
    input  logic [1:0]          dflt_port_i,
    input  logic [WSW-1:0]      dflt_ws_i,
    output logic                rd_en_o,
    output logic                wr_en_o,
    output logic                aack_o,
    output logic                burst_o,
    output logic [1:0]          port_o,
    output logic [WSW-1:0]      ws_o
);

    always_comb begin
        if (hit_i) begin
            rd_en_o = 1'b0;
            wr_en_o = 1'b0;
            aack_o  = 1'b0;
            burst_o = 1'b0;
            port_o  = '0;
            ws_o    = '0;
            for (int i = 0; i < NWIN; i++) begin
                if (sel_i[i]) begin
                    rd_en_o = rd_en_o | win_rd_en_i[i];
                    wr_en_o = wr_en_o | win_wr_en_i[i];
                    aack_o  = aack_o  | win_aack_i[i];
                    burst_o = burst_o | win_burst_i[i];
                    port_o  = port_o  | win_port_i[i*2 +: 2];
                    ws_o    = ws_o    | win_ws_i[i*WSW +: WSW];
                end
            end
        end else begin
            rd_en_o = 1'b1;
            wr_en_o = 1'b1;
            aack_o  = dflt_aack_i;
            burst_o = dflt_burst_i;
            port_o  = dflt_port_i;
            ws_o    = dflt_ws_i;
        end
    end

endmodule

// File: rtl/emcs_shape.sv
// Beat count and byte lanes from transfer size, port width and address offset.
module emcs_shape import emcs_pkg::*; (
    input  logic [1:0] size_i,
    input  logic [1:0] port_i,
    input  logic       burst_i,
    input  logic [1:0] ofs_i,
    output logic [4:0] beats_o,
    output logic [3:0] lanes_o
);

    logic [2:0] xl;
    logic [2:0] pl;
    logic [2:0] el;
    logic [2:0] eb;
    logic [3:0] fill;
    logic [1:0] pm;
    logic [1:0] em;
    logic [1:0] ofs;

    always_comb begin
        xl      = xfer_log2(size_i);
        pl      = port_log2(port_i);
        el      = (xl > pl) ? pl : xl;
        eb      = 3'd1 << el;
        fill    = 4'((5'd1 << eb) - 5'd1);
        pm      = 2'((3'd1 << pl) - 3'd1);
        em      = 2'((3'd1 << el) - 3'd1);
        ofs     = ofs_i & pm & ~em;
        lanes_o = fill << ofs;
        beats_o = (burst_i && (xl > pl)) ? (5'd1 << (xl - pl)) : 5'd1;
    end

endmodule

// File: rtl/emcs_ctrl.sv
module emcs_ctrl import emcs_pkg::*; #(
    parameter int NWIN    = 4,
    parameter int AW      = 28,
    parameter int WSW     = 4,
    parameter int HI_BITS = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ext_grant_i,
    input  logic                ts_i,
    input  logic [AW-1:0]       addr_i,
    input  logic                rd_i,
    input  logic [1:0]          size_i,
    input  logic                hi_addr_en_i,
    input  logic [NWIN*AW-1:0]  win_base_i,
    input  logic [NWIN*AW-1:0]  win_mask_i,
    input  logic [NWIN-1:0]     win_rd_en_i,
    input  logic [NWIN-1:0]     win_wr_en_i,
    input  logic [NWIN-1:0]     win_aack_i,
    input  logic [NWIN-1:0]     win_burst_i,
    input  logic [NWIN*2-1:0]   win_port_i,
    input  logic [NWIN*WSW-1:0] win_ws_i,
    input  logic                dflt_aack_i,
    input  logic                dflt_burst_i,
    input  logic [1:0]          dflt_port_i,
    input  logic [WSW-1:0]      dflt_ws_i,
    output logic [NWIN-1:0]     cs_o,
    output logic [3:0]          we_o,
    output logic                ta_o,
    output logic                ta_oe_o
);

    localparam int BW     = 5;            // up to 16 beats
    localparam int HI_LSB = AW - HI_BITS;

    typedef struct packed {
        emcs_state_e     st;
        logic [AW-1:0]   addr;
        logic            rd;
        logic [1:0]      size;
        logic [NWIN-1:0] cs;
        logic [3:0]      we;
        logic            oe;
        logic            beat;
        logic [WSW-1:0]  ws;
        logic [WSW-1:0]  cnt;
        logic [BW-1:0]   left;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic [AW-1:0]   cap_addr;
    logic [NWIN-1:0] m_sel;
    logic            m_hit;
    logic            r_rd_en;
    logic            r_wr_en;
    logic            r_aack;
    logic            r_burst;
    logic [1:0]      r_port;
    logic [WSW-1:0]  r_ws;
    logic [BW-1:0]   s_beats;
    logic [3:0]      s_lanes;
    logic            beat_w;

    emcs_match #(.NWIN(NWIN), .AW(AW)) u_match (
        .addr_i (ctl_q.addr),
        .base_i (win_base_i),
        .mask_i (win_mask_i),
        .sel_o  (m_sel),
        .hit_o  (m_hit)
    );

    emcs_cfg_sel #(.NWIN(NWIN), .WSW(WSW)) u_cfg (
        .sel_i        (m_sel),
        .hit_i        (m_hit),
        .win_rd_en_i  (win_rd_en_i),
        .win_wr_en_i  (win_wr_en_i),
        .win_aack_i   (win_aack_i),
        .win_burst_i  (win_burst_i),
        .win_port_i   (win_port_i),
        .win_ws_i     (win_ws_i),
        .dflt_aack_i  (dflt_aack_i),
        .dflt_burst_i (dflt_burst_i),
        .dflt_port_i  (dflt_port_i),
        .dflt_ws_i    (dflt_ws_i),
        .rd_en_o      (r_rd_en),
        .wr_en_o      (r_wr_en),
        .aack_o       (r_aack),
        .burst_o      (r_burst),
        .port_o       (r_port),
        .ws_o         (r_ws)
    );

    emcs_shape u_shape (
        .size_i  (ctl_q.size),
        .port_i  (r_port),
        .burst_i (r_burst),
        .ofs_i   (ctl_q.addr[1:0]),
        .beats_o (s_beats),
        .lanes_o (s_lanes)
    );

    always_comb begin
        ctl_d    = ctl_q;
        cap_addr = addr_i;
        if (!hi_addr_en_i) begin
            cap_addr[AW-1:HI_LSB] = '0;
        end
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ext_grant_i && ts_i) begin
                    ctl_d.st   = ST_DECODE;
                    ctl_d.addr = cap_addr;
                    ctl_d.rd   = rd_i;
                    ctl_d.size = size_i;
                end
            end
            ST_DECODE: begin
                if ((ctl_q.rd && r_rd_en) || (!ctl_q.rd && r_wr_en)) begin
                    ctl_d.st   = ST_RUN;
                    ctl_d.cs   = m_sel;
                    ctl_d.we   = (!ctl_q.rd && m_hit) ? s_lanes : 4'b0000;
                    ctl_d.oe   = r_aack;
                    ctl_d.ws   = r_ws;
                    ctl_d.cnt  = r_ws;
                    ctl_d.left = s_beats;
                    ctl_d.beat = (r_ws == '0);
                end else begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (ctl_q.beat) begin
                    if (ctl_q.left == BW'(1)) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.cs   = '0;
                        ctl_d.we   = '0;
                        ctl_d.oe   = 1'b0;
                        ctl_d.beat = 1'b0;
                        ctl_d.left = '0;
                    end else begin
                        ctl_d.left = ctl_q.left - BW'(1);
                        ctl_d.cnt  = ctl_q.ws;
                        ctl_d.beat = (ctl_q.ws == '0);
                    end
                end else if (ctl_q.cnt == WSW'(1)) begin
                    ctl_d.cnt  = '0;
                    ctl_d.beat = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - WSW'(1);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign beat_w  = ctl_q.beat;
    assign cs_o    = ctl_q.cs;
    assign we_o    = ctl_q.we;
    assign ta_oe_o = ctl_q.oe;
    assign ta_o    = ctl_q.beat & ctl_q.oe;

endmodule

// File: rtl/emcs_ctrl_chk.sv
module emcs_ctrl_chk #(
    parameter int NWIN = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            ext_grant_i,
    input logic            ts_i,
    input logic [NWIN-1:0] cs_o,
    input logic [3:0]      we_o,
    input logic            ta_o,
    input logic            ta_oe_o,
    input logic            beat_w
);

    // R3: never more than one chip select
    p_cs_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(cs_o));

    // R5: acknowledge pulses only while the acknowledge is driven
    p_ta_driven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ta_o |-> ta_oe_o);

    // R9: write enables only go with a window chip select
    p_we_with_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|we_o) |-> (|cs_o));

    // R2: a chip select rises two edges after a granted strobe
    p_cs_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(|cs_o) |-> $past(ts_i && ext_grant_i, 2));

    // R10: chip select only falls right after a beat completes
    p_cs_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(|cs_o) |-> $past(beat_w));

endmodule

bind emcs_ctrl emcs_ctrl_chk #(.NWIN(NWIN)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_grant_i (ext_grant_i),
    .ts_i        (ts_i),
    .cs_o        (cs_o),
    .we_o        (we_o),
    .ta_o        (ta_o),
    .ta_oe_o     (ta_oe_o),
    .beat_w      (beat_w)
);

// File: tb/test_emcs_ctrl.sv
`timescale 1ns/1ps
module test_emcs_ctrl;

    localparam int NWIN = 4;
    localparam int AW   = 28;
    localparam int WSW  = 4;
    localparam int EW   = NWIN + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            grant = 1'b1;
    logic            ts = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic            rdw = 1'b1;
    logic [1:0]      size = 2'b00;
    logic            hi_en = 1'b1;

    logic [AW-1:0]   base [NWIN];
    logic [AW-1:0]   mask [NWIN];
    logic [NWIN-1:0] rde, wre, aack, burst;
    logic [1:0]      port [NWIN];
    logic [WSW-1:0]  ws   [NWIN];
    logic            d_aack = 1'b1, d_burst = 1'b1;
    logic [1:0]      d_port = 2'b10;
    logic [WSW-1:0]  d_ws = 4'd3;

    logic [NWIN*AW-1:0]  f_base, f_mask;
    logic [NWIN*2-1:0]   f_port;
    logic [NWIN*WSW-1:0] f_ws;

    always_comb begin
        for (int i = 0; i < NWIN; i++) begin
            f_base[i*AW +: AW]   = base[i];
            f_mask[i*AW +: AW]   = mask[i];
            f_port[i*2 +: 2]     = port[i];
            f_ws[i*WSW +: WSW]   = ws[i];
        end
    end

    logic [NWIN-1:0] cs_o;
    logic [3:0]      we_o;
    logic            ta_o, ta_oe_o;

    emcs_ctrl #(.NWIN(NWIN), .AW(AW), .WSW(WSW), .HI_BITS(4)) i_emcs_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .ext_grant_i(grant), .ts_i(ts),
        .addr_i(addr), .rd_i(rdw), .size_i(size), .hi_addr_en_i(hi_en),
        .win_base_i(f_base), .win_mask_i(f_mask), .win_rd_en_i(rde),
        .win_wr_en_i(wre), .win_aack_i(aack), .win_burst_i(burst),
        .win_port_i(f_port), .win_ws_i(f_ws), .dflt_aack_i(d_aack),
        .dflt_burst_i(d_burst), .dflt_port_i(d_port), .dflt_ws_i(d_ws),
        .cs_o(cs_o), .we_o(we_o), .ta_o(ta_o), .ta_oe_o(ta_oe_o)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R13";
    bit    done = 0;

    task automatic chk_vec(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: cycle compare got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    // entry = {cs, we, ta, ta_oe}
    logic [EW-1:0] q_exp[$];
    logic [EW-1:0] exp_now = '0;
    bit            prev_busy = 0;

    task automatic plan(input logic [AW-1:0] a, input bit rd, input logic [1:0] sz);
        int w = -1;
        int bytes, pbytes, beats, nws, n, off;
        bit ack_en, b_en;
        logic [1:0] pc;
        logic [3:0] lanes;
        logic [NWIN-1:0] sel;
        logic [AW-1:0] ea;
        ea = hi_en ? a : {4'h0, a[AW-5:0]};
        for (int i = NWIN - 1; i >= 0; i--)
            if (((ea ^ base[i]) & mask[i]) == '0) w = i;
        q_exp.push_back('0);                       // decode clock
        if (w >= 0) begin
            if (rd ? !rde[w] : !wre[w]) return;    // direction disabled
            pc = port[w]; nws = int'(ws[w]); ack_en = aack[w]; b_en = burst[w];
        end else begin
            pc = d_port; nws = int'(d_ws); ack_en = d_aack; b_en = d_burst;
        end
        bytes  = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : (sz == 2'b11) ? 16 : 4;
        pbytes = (pc == 2'b00) ? 1 : (pc == 2'b01) ? 2 : 4;
        beats  = (b_en && bytes > pbytes) ? bytes / pbytes : 1;
        lanes  = '0;
        if (!rd && w >= 0) begin
            n   = (bytes < pbytes) ? bytes : pbytes;
            off = (int'(ea[1:0]) % pbytes) / n * n;
            for (int k = 0; k < n; k++) lanes[off + k] = 1'b1;
        end
        sel = '0;
        if (w >= 0) sel[w] = 1'b1;
        for (int b = 0; b < beats; b++)
            for (int c = 0; c <= nws; c++)
                q_exp.push_back({sel, lanes, (c == nws) && ack_en, ack_en});
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q_exp.delete();
            exp_now   = '0;
            prev_busy = 0;
        end else begin
            if (!prev_busy && q_exp.size() == 0 && grant && ts) plan(addr, rdw, size);
            if (q_exp.size() > 0) begin
                exp_now   = q_exp.pop_front();
                prev_busy = 1;
            end else begin
                exp_now   = '0;
                prev_busy = 0;
            end
        end
    end

    // per-clock comparison and observation counters
    int            ta_cnt = 0;
    int            cs_cyc = 0;
    logic [3:0]    we_seen = '0;
    logic [NWIN-1:0] cs_seen = '0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk_vec(cur_req, {cs_o, we_o, ta_o, ta_oe_o}, exp_now);
            ta_cnt  += int'(ta_o);
            cs_cyc  += int'(|cs_o);
            we_seen |= we_o;
            cs_seen |= cs_o;
        end
    end

    task automatic xfer(input string req, input logic [AW-1:0] a, input bit rd,
                        input logic [1:0] sz, input bit g, input int e_ta, input int e_cs,
                        input logic [3:0] e_we, input logic [NWIN-1:0] e_sel);
        cur_req = req;
        @(negedge clk);
        ta_cnt = 0; cs_cyc = 0; we_seen = '0; cs_seen = '0;
        grant = g; addr = a; rdw = rd; size = sz; ts = 1'b1;
        @(negedge clk);
        ts = 1'b0; grant = 1'b1;
        repeat (40) @(negedge clk);
        chk_int(req, "ack pulses", ta_cnt, e_ta);
        chk_int(req, "chip-select clocks", cs_cyc, e_cs);
        chk_int(req, "write lanes", int'(we_seen), int'(e_we));
        chk_int(req, "selected window", int'(cs_seen), int'(e_sel));
    endtask

    initial begin
        // win0: 0x0110_0000, 32-bit, 2 ws, ack, burst, rd+wr
        base[0] = 28'h011_0000; mask[0] = 28'hFFF_0000; port[0] = 2'b10; ws[0] = 4'd2;
        // win1: 0x0020_0000, 8-bit, 0 ws, ack, burst, read only
        base[1] = 28'h020_0000; mask[1] = 28'hFFF_0000; port[1] = 2'b00; ws[1] = 4'd0;
        // win2: 0x0030_0000, 16-bit, 1 ws, no ack, no burst, rd+wr
        base[2] = 28'h030_0000; mask[2] = 28'hFFF_0000; port[2] = 2'b01; ws[2] = 4'd1;
        // win3: 0x01xx_xxxx, 32-bit, 1 ws, ack, burst, rd+wr (overlaps win0)
        base[3] = 28'h100_0000; mask[3] = 28'hF00_0000; port[3] = 2'b10; ws[3] = 4'd1;
        rde   = 4'b1111;
        wre   = 4'b1101;
        aack  = 4'b1011;
        burst = 4'b1011;
        base[0] = 28'h110_0000;

        repeat (3) @(negedge clk);
        // R13: reset state
        chk_int("R13", "outputs in reset", int'({cs_o, we_o, ta_o, ta_oe_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_int("R13", "outputs after reset", int'({cs_o, we_o, ta_o, ta_oe_o}), 0);

        // R2: capture and first chip-select timing
        cur_req = "R2";
        addr = 28'h110_0004; rdw = 1'b1; size = 2'b00; ts = 1'b1;
        @(negedge clk); ts = 1'b0;
        chk_int("R2", "cs one clock after strobe", int'(cs_o), 0);
        @(negedge clk);
        chk_int("R2", "cs two clocks after strobe", int'(cs_o), 1);
        repeat (10) @(negedge clk);

        xfer("R5", 28'h110_0004, 1'b1, 2'b00, 1'b1, 1, 3, 4'b0000, 4'b0001);
        xfer("R8", 28'h110_0000, 1'b1, 2'b11, 1'b1, 4, 12, 4'b0000, 4'b0001);
        xfer("R9", 28'h110_0002, 1'b0, 2'b01, 1'b1, 1, 3, 4'b0100, 4'b0001);
        xfer("R9", 28'h110_0002, 1'b0, 2'b10, 1'b1, 1, 3, 4'b1100, 4'b0001);
        xfer("R8", 28'h020_0000, 1'b1, 2'b10, 1'b1, 2, 2, 4'b0000, 4'b0010);
        xfer("R4", 28'h020_0000, 1'b0, 2'b00, 1'b1, 0, 0, 4'b0000, 4'b0000);
        xfer("R6", 28'h030_0000, 1'b0, 2'b00, 1'b1, 0, 2, 4'b0011, 4'b0100);
        xfer("R9", 28'h030_0003, 1'b0, 2'b01, 1'b1, 0, 2, 4'b0010, 4'b0100);
        xfer("R7", 28'h050_0000, 1'b1, 2'b00, 1'b1, 1, 0, 4'b0000, 4'b0000);
        xfer("R7", 28'h050_0000, 1'b0, 2'b11, 1'b1, 4, 0, 4'b0000, 4'b0000);
        xfer("R1", 28'h110_0000, 1'b1, 2'b00, 1'b0, 0, 0, 4'b0000, 4'b0000);
        xfer("R3", 28'h180_0000, 1'b1, 2'b00, 1'b1, 1, 2, 4'b0000, 4'b1000);
        xfer("R3", 28'h110_0000, 1'b0, 2'b00, 1'b1, 1, 3, 4'b1111, 4'b0001);

        // R12: upper address bits zeroed when not address pins
        hi_en = 1'b0;
        xfer("R12", 28'h520_0010, 1'b1, 2'b01, 1'b1, 1, 1, 4'b0000, 4'b0010);
        hi_en = 1'b1;
        xfer("R12", 28'h520_0010, 1'b1, 2'b01, 1'b1, 1, 0, 4'b0000, 4'b0000);

        // R11 / R10: strobe held high across busy clocks
        cur_req = "R11";
        @(negedge clk);
        ta_cnt = 0; cs_cyc = 0;
        addr = 28'h020_0001; rdw = 1'b1; size = 2'b01; ts = 1'b1;
        repeat (9) @(negedge clk);
        ts = 1'b0;
        repeat (10) @(negedge clk);
        chk_int("R11", "captures while strobe held", ta_cnt, 3);
        chk_int("R10", "cs clocks back to back", cs_cyc, 3);

        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_up();
    end

endmodule